// File: doc/BRIEF.md
# Serial-to-Parallel Shift Register with Holding Stage

The block turns a serial bit stream into a parallel word. Bits enter a chain of flip-flops on the rising edge of a shift clock. A separate holding register drives the parallel outputs. That register takes a copy of the whole chain on the rising edge of its own store clock. The parallel outputs therefore change only when the host asks for an update, and never while bits are still moving through the chain.

Each register has its own asynchronous active-low clear, so the chain can be emptied while the held word stays on the outputs, and the outputs can be blanked without losing bits in flight. The last stage of the chain is brought out as a serial output. Wiring that output to the serial input of a further instance, with the clocks shared, makes a longer chain.

When both clocks rise at the same instant, the holding register takes the chain contents from before that shift. As a result the chain always stays one shift ahead of the holding register.

Top module: `sipo_store_reg`

## Requirements
- R1: On a rising shift-clock edge, ser_i enters stage 0 and each stage n takes the previous value of stage n-1, with no inversion. After W shifts the first bit sent is in stage W-1, which a store places on par_o bit W-1.
- R2: ser_o always equals the last shift stage (W-1). After a shift, it shows what stage W-2 held before that shift.
- R3: On a rising store-clock edge, the holding register copies the shift stages, and par_o[n] is stage n. par_o shows only the holding register, so shift edges without a store edge leave par_o unchanged.
- R4: While shift_rst_ni is low, all shift stages and ser_o are 0 without waiting for a clock edge, and par_o keeps its value.
- R5: While store_rst_ni is low, par_o is 0 without waiting for a clock edge, and the shift stages (seen at ser_o) keep their values.
- R6: A store edge while shift_rst_ni is held low loads all zeros into par_o.
- R7: When both clocks rise together, par_o takes the shift contents from before that shift.
- R8: While a clear is held low it overrides its register's clock. Once the clear is released, the register works again from the next rising edge.
- R9: Two instances chained ser_o to ser_i, with shared clocks, form a 2W-bit chain. After 2W shifts and one store, the second instance's par_o holds the first W bits sent and the first instance's par_o holds the last W bits sent.
- R10: After both clears, par_o is 0 and ser_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| shift_clk_i | input | 1 | Shift clock, acts on its rising edge |
| store_clk_i | input | 1 | Store clock, acts on its rising edge |
| shift_rst_ni | input | 1 | Asynchronous active-low clear of the shift stages |
| store_rst_ni | input | 1 | Asynchronous active-low clear of the holding register |
| ser_i | input | 1 | Serial data in |
| ser_o | output | 1 | Last shift stage, used for cascading |
| par_o | output | W | Holding register contents |

## Verification
Both clocks are gated copies of one base clock, with the enables changed at the falling edge. A shift or store therefore shows at ser_o or par_o within the same base cycle as its edge, and the bench samples at the following falling edge. The clears take effect with no clock at all: the bench asserts a clear between edges, checks a couple of nanoseconds later, and releases the clear before the next rising edge. For the clear-held cases, the clear stays low across the edge instead. A bench model updated once per base cycle gives the expected values, and it reads the pre-edge shift contents whenever a store edge occurs, including when both clocks rise together.

// File: rtl/sipo_pkg.sv
package sipo_pkg;
  parameter int unsigned SIPO_W_DEF = 8;
endpackage

// File: rtl/sipo_shift_chain.sv
module sipo_shift_chain #(
  parameter int unsigned W = sipo_pkg::SIPO_W_DEF
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q;

  for (genvar i = 0; i < W; i++) begin : g_stage
    logic nxt;
    if (i == 0) begin : g_head
      assign nxt = d_i;
    end else begin : g_body
      assign nxt = stage_q[i-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[i] <= 1'b0;
      else         stage_q[i] <= nxt;
    end
  end

  assign q_o = stage_q;
endmodule

// File: rtl/sipo_hold_reg.sv
module sipo_hold_reg #(
  parameter int unsigned W = sipo_pkg::SIPO_W_DEF
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= d_i;
  end
endmodule

// File: rtl/sipo_store_reg.sv
module sipo_store_reg #(
  parameter int unsigned W = sipo_pkg::SIPO_W_DEF
) (
  input  logic         shift_clk_i,
  input  logic         store_clk_i,
  input  logic         shift_rst_ni,
  input  logic         store_rst_ni,
  input  logic         ser_i,
  output logic         ser_o,
  output logic [W-1:0] par_o
);
  localparam int unsigned LAST = W - 1;

  logic [W-1:0] shift_q;
  logic [W-1:0] hold_q;

  sipo_shift_chain #(.W(W)) u_chain (
    .clk_i  (shift_clk_i),
    .rst_ni (shift_rst_ni),
    .d_i    (ser_i),
    .q_o    (shift_q)
  );

  // holding register samples the pre-shift chain when both clocks rise together
  sipo_hold_reg #(.W(W)) u_hold (
    .clk_i  (store_clk_i),
    .rst_ni (store_rst_ni),
    .d_i    (shift_q),
    .q_o    (hold_q)
  );

  assign ser_o = shift_q[LAST];
  assign par_o = hold_q;
endmodule

// File: rtl/sipo_store_reg_chk.sv
module sipo_store_reg_chk #(
  parameter int unsigned W = sipo_pkg::SIPO_W_DEF
) (
  input logic         shift_clk_i,
  input logic         store_clk_i,
  input logic         shift_rst_ni,
  input logic         store_rst_ni,
  input logic         ser_o,
  input logic [W-1:0] par_o,
  input logic [W-1:0] shift_q
);
  // R4
  shift_clr_ser_chk: assert property (@(posedge store_clk_i) disable iff (!store_rst_ni)
    !shift_rst_ni |-> ser_o == 1'b0);

  // R4
  shift_clr_stage_chk: assert property (@(posedge store_clk_i) disable iff (!store_rst_ni)
    !shift_rst_ni |-> shift_q == '0);

  // R5
  store_clr_par_chk: assert property (@(posedge shift_clk_i) disable iff (!shift_rst_ni)
    !store_rst_ni |-> par_o == '0);

  // R6
  zero_load_chk: assert property (@(posedge store_clk_i) disable iff (!store_rst_ni)
    !shift_rst_ni |=> par_o == '0);
endmodule

bind sipo_store_reg sipo_store_reg_chk #(.W(W)) u_chk (
  .shift_clk_i  (shift_clk_i),
  .store_clk_i  (store_clk_i),
  .shift_rst_ni (shift_rst_ni),
  .store_rst_ni (store_rst_ni),
  .ser_o        (ser_o),
  .par_o        (par_o),
  .shift_q      (shift_q)
);

// File: tb/test_sipo_store_reg.sv
module test_sipo_store_reg;
  localparam int unsigned W  = 8;
  localparam int unsigned W2 = 2 * W;

  logic clk = 1'b0;
  logic sh_en = 1'b0, st_en = 1'b0, din = 1'b0;
  logic sh_rst_n = 1'b0, st_rst_n = 1'b0;
  logic sh_clk, st_clk;
  logic ser_a, ser_b;
  logic [W-1:0] par_a, par_b;

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;
  logic [W2-1:0] m_sh = '0, m_st = '0;

  always #10 clk = ~clk;
  // enables change only while clk is low, so the gated clocks are clean
  assign sh_clk = clk & sh_en;
  assign st_clk = clk & st_en;

  sipo_store_reg #(.W(W)) i_sipo_store_reg (
    .shift_clk_i(sh_clk), .store_clk_i(st_clk), .shift_rst_ni(sh_rst_n),
    .store_rst_ni(st_rst_n), .ser_i(din), .ser_o(ser_a), .par_o(par_a));

  sipo_store_reg #(.W(W)) i_sipo_store_reg_b (
    .shift_clk_i(sh_clk), .store_clk_i(st_clk), .shift_rst_ni(sh_rst_n),
    .store_rst_ni(st_rst_n), .ser_i(ser_a), .ser_o(ser_b), .par_o(par_b));

  task automatic chk(input bit ok, input string tag, input logic [W2-1:0] act,
                     input logic [W2-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all();
    chk(par_a == m_st[W-1:0], "R3 par", W2'(par_a), W2'(m_st[W-1:0]));
    chk(par_b == m_st[W2-1:W], "R9 par", W2'(par_b), W2'(m_st[W2-1:W]));
    chk(ser_a == m_sh[W-1], "R2 ser", W2'(ser_a), W2'(m_sh[W-1]));
    chk(ser_b == m_sh[W2-1], "R2 ser", W2'(ser_b), W2'(m_sh[W2-1]));
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic step(input bit sh, input bit st, input bit d);
    sh_en = sh; st_en = st; din = d;
    @(posedge clk);
    if (!st_rst_n)  m_st = '0;
    else if (st)    m_st = m_sh;
    if (!sh_rst_n)  m_sh = '0;
    else if (sh)    m_sh = {m_sh[W2-2:0], d};
    @(negedge clk);
    check_all();
  endtask

  // clear pulse between edges, optionally held
  task automatic clr(input bit c_sh, input bit c_st, input bit rel);
    sh_en = 1'b0; st_en = 1'b0;
    #2;
    if (c_sh) begin sh_rst_n = 1'b0; m_sh = '0; end
    if (c_st) begin st_rst_n = 1'b0; m_st = '0; end
    #2;
    if (c_sh) begin
      chk(ser_a == 1'b0 && ser_b == 1'b0, "R4 ser", W2'({ser_b, ser_a}), '0);
      chk({par_b, par_a} == m_st, "R4 par kept", {par_b, par_a}, m_st);
    end
    if (c_st) begin
      chk({par_b, par_a} == '0, "R5 par", {par_b, par_a}, '0);
      chk(ser_a == m_sh[W-1] && ser_b == m_sh[W2-1], "R5 shift kept",
          W2'({ser_b, ser_a}), W2'({m_sh[W2-1], m_sh[W-1]}));
    end
    if (rel) begin #2; sh_rst_n = 1'b1; st_rst_n = 1'b1; end
    @(negedge clk);
  endtask

  task automatic send(input logic [W2-1:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) step(1'b1, 1'b0, v[i]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    logic [W2-1:0] v;
    seed = $urandom(32'd20240);
    @(negedge clk);
    @(negedge clk);
    // R10
    chk(par_a == '0 && par_b == '0 && ser_a == 1'b0 && ser_b == 1'b0, "R10 reset",
        {par_b, par_a}, '0);
    sh_rst_n = 1'b1; st_rst_n = 1'b1;
    @(negedge clk);

    // R1: first bit sent lands in stage W-1
    send(W2'(8'hA5), W);
    step(1'b0, 1'b1, 1'b0);
    chk(par_a == 8'hA5, "R1 order", W2'(par_a), W2'(8'hA5));
    // R3: shifts without a store leave par_o alone
    send(W2'(8'h3C), W);
    chk(par_a == 8'hA5, "R3 hold", W2'(par_a), W2'(8'hA5));
    // R7: both edges together store pre-shift contents
    step(1'b1, 1'b1, 1'b1);
    chk(par_a == 8'h3C, "R7 same edge", W2'(par_a), W2'(8'h3C));
    chk(par_b == 8'hA5, "R7 cascade", W2'(par_b), W2'(8'hA5));

    // R4 / R5 pulses between edges
    clr(1'b1, 1'b0, 1'b1);
    send(W2'(8'hF0), W);
    clr(1'b0, 1'b1, 1'b1);

    // R8 / R6: shift clear held across edges
    clr(1'b1, 1'b0, 1'b0);
    step(1'b1, 1'b0, 1'b1);
    chk(ser_a == 1'b0 && ser_b == 1'b0, "R8 held", W2'({ser_b, ser_a}), '0);
    step(1'b0, 1'b1, 1'b0);
    chk({par_b, par_a} == '0, "R6 zero load", {par_b, par_a}, '0);
    sh_rst_n = 1'b1;
    step(1'b1, 1'b0, 1'b1);
    send('0, W - 1);
    chk(ser_a == 1'b1, "R8 resume", W2'(ser_a), W2'(1));
    // R8: store clear held overrides store edge
    clr(1'b0, 1'b1, 1'b0);
    step(1'b0, 1'b1, 1'b0);
    chk({par_b, par_a} == '0, "R8 store held", {par_b, par_a}, '0);
    st_rst_n = 1'b1;
    step(1'b0, 1'b1, 1'b0);

    // R9: 2W-bit cascade
    for (int k = 0; k < 4; k++) begin
      v = W2'($urandom());
      send(v, W2);
      step(1'b0, 1'b1, 1'b0);
      chk({par_b, par_a} == v, "R9 cascade", {par_b, par_a}, v);
    end

    // random mix against the model
    for (int k = 0; k < 400; k++) begin
      if ($urandom_range(19) == 0)
        clr(1'($urandom()), 1'($urandom()), 1'b1);
      else
        step(1'($urandom()), 1'($urandom()), 1'($urandom()));
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule